// File: doc/BRIEF.md
# Peripheral Domain Access Controller

The block sits beside a bus fabric. It decides whether a bus access may reach its target peripheral. Each master is given one of four isolation domains. Each peripheral carries a policy word that lists, per domain, whether reads and writes are allowed. The policy word also carries a flag saying that the peripheral is shared and must be arbitrated through a semaphore. Both tables are loaded through a plain register port with write and read strobes. Any word can be frozen by setting its lock bit, and a frozen word stays fixed until the next reset.

For each access request the block takes the master index, the peripheral index and a direction flag. It looks up the master's domain and tests the matching enable bit in the peripheral's policy word. One clock later it answers with a grant or a one-cycle deny pulse. The semaphore flag of that peripheral is reported alongside the answer. The answer is held in a three-state machine.

The three states are:
- `AG_IDLE`: no response is being presented.
- `AG_GRANT`: the previous cycle carried an allowed access.
- `AG_DENY`: the previous cycle carried a refused access.

The state register is updated on every clock, and each transition depends only on the request seen in that clock:
- Into `AG_IDLE`: from any state, when no request is present.
- Into `AG_GRANT`: from any state, when a request is present and allowed.
- Into `AG_DENY`: from any state, when a request is present and refused.

Because every state can be left every cycle, back-to-back requests give back-to-back responses.

Top module: `dom_guard_top`

## Requirements
- R1: After reset every master word reads 0, which places the master in domain 0 and leaves it unlocked. Every peripheral word reads 32'h0000_00FF, which allows read and write for all four domains, with no semaphore and no lock.
- R2: A write with `cfg_sel`=0 stores bits [1:0] (domain) and bit 31 (lock) of `cfg_wdata` into the master word at `cfg_idx`. All other bits read back as 0. The read data appears on `cfg_rdata` one clock after `cfg_rd` and then holds.
- R3: A write with `cfg_sel`=1 stores bits [7:0], bit 30 and bit 31 of `cfg_wdata` into the peripheral word at `cfg_idx`. All other bits read back as 0.
- R4: Once bit 31 of a stored word is 1, any later write to that word leaves it unchanged until reset. This applies to both tables.
- R5: A read access (`acc_write`=0) is granted only when bit 2d+1 of the target peripheral word is 1, where d is the requesting master's domain.
- R6: A write access (`acc_write`=1) is granted only when bit 2d of the target peripheral word is 1.
- R7: The clock edge that samples `acc_valid`=1 raises `acc_done` together with exactly one of `acc_grant` or `acc_deny`. These last one cycle per request, and back-to-back requests are answered back to back. With no request, all three outputs stay 0.
- R8: `acc_sema_req` carries bit 30 of the target peripheral word, in the same cycle as the response. It is 0 when no response is shown.
- R9: A master index or peripheral index at or beyond the table size causes a deny. If only the master index is out of range, `acc_sema_req` still carries the peripheral's flag. If the peripheral index is out of range, `acc_sema_req` is 0. Configuration writes to an out-of-range index have no effect, and reads from one return 0.
- R10: An access in the same cycle as a configuration write to a word it uses is decided on the contents before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_sel | input | 1 | Table select: 0 selects the master table, 1 selects the peripheral table |
| cfg_idx | input | 8 | Entry index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| acc_valid | input | 1 | Access request present |
| acc_master | input | 8 | Requesting master index |
| acc_periph | input | 8 | Target peripheral index |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| acc_done | output | 1 | Response present |
| acc_grant | output | 1 | Access allowed |
| acc_deny | output | 1 | Access refused (one-cycle pulse) |
| acc_sema_req | output | 1 | Target peripheral needs semaphore arbitration |

## Verification
Table programming and access checking can fall in the same cycle. The bench raises `cfg_wr` on a peripheral word together with a read request to that same peripheral. It expects the response to reflect the word's old contents, and expects a second request one cycle later to see the new contents. Back-to-back requests with mixed directions also overlap a new request with the previous response, and each response is matched in order against a scoreboard queue.

// File: rtl/dg_pkg.sv
package dg_pkg;
    localparam int DG_WORD_W   = 32;
    localparam int DG_DOM_W    = 2;
    localparam int DG_NDOM     = 4;
    localparam int DG_LOCK_BIT = 31;
    localparam int DG_SEMA_BIT = 30;

    localparam logic [DG_WORD_W-1:0] MA_KEEP  = 32'h8000_0003;
    localparam logic [DG_WORD_W-1:0] MA_RESET = 32'h0000_0000;
    localparam logic [DG_WORD_W-1:0] PA_KEEP  = 32'hC000_00FF;
    localparam logic [DG_WORD_W-1:0] PA_RESET = 32'h0000_00FF;

    typedef enum logic [1:0] {
        AG_IDLE  = 2'd0,
        AG_GRANT = 2'd1,
        AG_DENY  = 2'd2
    } ag_state_e;

    // Permission bit of a policy word for a domain and direction
    function automatic logic perm_bit(input logic [DG_WORD_W-1:0] pol,
                                      input logic [DG_DOM_W-1:0] dom,
                                      input logic is_wr);
        logic [DG_WORD_W-1:0] sh;
        sh = pol >> {dom, ~is_wr};
        return sh[0];
    endfunction
endpackage

// File: rtl/dg_master_tbl.sv
module dg_master_tbl
    import dg_pkg::*;
#(
    parameter int N_MASTERS = 16,
    parameter int ID_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ID_W-1:0]       cfg_idx,
    input  logic [DG_WORD_W-1:0]  wdata,
    output logic [DG_WORD_W-1:0]  rd_word,
    input  logic [ID_W-1:0]       lk_idx,
    output logic [DG_DOM_W-1:0]   lk_dom,
    output logic                  lk_hit
);
    localparam int IDX_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
    localparam logic [ID_W:0] LIM = (ID_W+1)'(N_MASTERS);

    logic [DG_WORD_W-1:0] word_q [N_MASTERS];
    logic                 cfg_hit;
    logic [IDX_W-1:0]     cfg_t, lk_t;

    assign cfg_hit = ({1'b0, cfg_idx} < LIM);
    assign lk_hit  = ({1'b0, lk_idx} < LIM);
    assign cfg_t   = cfg_idx[IDX_W-1:0];
    assign lk_t    = lk_idx[IDX_W-1:0];

    for (genvar i = 0; i < N_MASTERS; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[i] <= MA_RESET;
            end else if (we && cfg_hit && (cfg_t == IDX_W'(i)) && !word_q[i][DG_LOCK_BIT]) begin
                word_q[i] <= wdata & MA_KEEP;
            end
        end

        // R4: a locked master word never changes
        assert_ma_locked_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
            word_q[i][DG_LOCK_BIT] |=> $stable(word_q[i]));
    end

    always_comb begin
        rd_word = '0;
        if (cfg_hit) rd_word = word_q[cfg_t];
    end

    always_comb begin
        lk_dom = '0;
        if (lk_hit) lk_dom = word_q[lk_t][DG_DOM_W-1:0];
    end
endmodule

// File: rtl/dg_policy_tbl.sv
module dg_policy_tbl
    import dg_pkg::*;
#(
    parameter int N_PERIPHS = 16,
    parameter int ID_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ID_W-1:0]       cfg_idx,
    input  logic [DG_WORD_W-1:0]  wdata,
    output logic [DG_WORD_W-1:0]  rd_word,
    input  logic [ID_W-1:0]       lk_idx,
    output logic [DG_WORD_W-1:0]  lk_word,
    output logic                  lk_hit
);
    localparam int IDX_W = (N_PERIPHS > 1) ? $clog2(N_PERIPHS) : 1;
    localparam logic [ID_W:0] LIM = (ID_W+1)'(N_PERIPHS);

    logic [DG_WORD_W-1:0] word_q [N_PERIPHS];
    logic                 cfg_hit;
    logic [IDX_W-1:0]     cfg_t, lk_t;

    assign cfg_hit = ({1'b0, cfg_idx} < LIM);
    assign lk_hit  = ({1'b0, lk_idx} < LIM);
    assign cfg_t   = cfg_idx[IDX_W-1:0];
    assign lk_t    = lk_idx[IDX_W-1:0];

    for (genvar i = 0; i < N_PERIPHS; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[i] <= PA_RESET;
            end else if (we && cfg_hit && (cfg_t == IDX_W'(i)) && !word_q[i][DG_LOCK_BIT]) begin
                word_q[i] <= wdata & PA_KEEP;
            end
        end

        // R4: a locked policy word never changes
        assert_pa_locked_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
            word_q[i][DG_LOCK_BIT] |=> $stable(word_q[i]));
    end

    always_comb begin
        rd_word = '0;
        if (cfg_hit) rd_word = word_q[cfg_t];
    end

    always_comb begin
        lk_word = '0;
        if (lk_hit) lk_word = word_q[lk_t];
    end
endmodule

// File: rtl/dg_decide_fsm.sv
module dg_decide_fsm
    import dg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic                  m_hit,
    input  logic                  p_hit,
    input  logic [DG_DOM_W-1:0]   dom,
    input  logic [DG_WORD_W-1:0]  pol,
    output logic                  done,
    output logic                  grant,
    output logic                  deny,
    output logic                  sema
);
    ag_state_e state_q, state_d;
    logic      sema_q, sema_d;
    logic      allow;

    assign allow = m_hit && p_hit && perm_bit(pol, dom, acc_write);

    always_comb begin
        state_d = AG_IDLE;
        sema_d  = 1'b0;
        if (acc_valid) begin
            state_d = allow ? AG_GRANT : AG_DENY;
            sema_d  = p_hit && pol[DG_SEMA_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AG_IDLE;
            sema_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            sema_q  <= sema_d;
        end
    end

    always_comb begin
        done  = 1'b0;
        grant = 1'b0;
        deny  = 1'b0;
        sema  = 1'b0;
        unique case (state_q)
            AG_IDLE:  ;
            AG_GRANT: begin done = 1'b1; grant = 1'b1; sema = sema_q; end
            AG_DENY:  begin done = 1'b1; deny  = 1'b1; sema = sema_q; end
            default:  ;
        endcase
    end

    // R7: every request is answered on the next clock, and nothing else is
    assert_done_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> done);
    assert_quiet_without_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !done && !grant && !deny && !sema);
    // R9: an unknown master or peripheral is always refused
    assert_range_deny_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !(m_hit && p_hit)) |=> deny);
    // R8: no semaphore flag without a response
    assert_sema_with_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sema |-> done);
endmodule

// File: rtl/dom_guard_top.sv
module dom_guard_top
    import dg_pkg::*;
#(
    parameter int N_MASTERS = 16,
    parameter int N_PERIPHS = 16,
    parameter int ID_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic                  cfg_rd,
    input  logic                  cfg_sel,
    input  logic [ID_W-1:0]       cfg_idx,
    input  logic [DG_WORD_W-1:0]  cfg_wdata,
    output logic [DG_WORD_W-1:0]  cfg_rdata,
    input  logic                  acc_valid,
    input  logic [ID_W-1:0]       acc_master,
    input  logic [ID_W-1:0]       acc_periph,
    input  logic                  acc_write,
    output logic                  acc_done,
    output logic                  acc_grant,
    output logic                  acc_deny,
    output logic                  acc_sema_req
);
    logic [DG_WORD_W-1:0] ma_rd, pa_rd, pa_lk, rdata_q;
    logic [DG_DOM_W-1:0]  m_dom;
    logic                 m_hit, p_hit;

    dg_master_tbl #(.N_MASTERS(N_MASTERS), .ID_W(ID_W)) u_mtbl (
        .clk(clk), .rst_n(rst_n), .we(cfg_wr && !cfg_sel),
        .cfg_idx(cfg_idx), .wdata(cfg_wdata), .rd_word(ma_rd),
        .lk_idx(acc_master), .lk_dom(m_dom), .lk_hit(m_hit));

    dg_policy_tbl #(.N_PERIPHS(N_PERIPHS), .ID_W(ID_W)) u_ptbl (
        .clk(clk), .rst_n(rst_n), .we(cfg_wr && cfg_sel),
        .cfg_idx(cfg_idx), .wdata(cfg_wdata), .rd_word(pa_rd),
        .lk_idx(acc_periph), .lk_word(pa_lk), .lk_hit(p_hit));

    dg_decide_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .m_hit(m_hit), .p_hit(p_hit), .dom(m_dom), .pol(pa_lk),
        .done(acc_done), .grant(acc_grant), .deny(acc_deny), .sema(acc_sema_req));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else if (cfg_rd) rdata_q <= cfg_sel ? pa_rd : ma_rd;
    end
    assign cfg_rdata = rdata_q;

    // R2: read data holds when no read strobe was given
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> $stable(cfg_rdata));
endmodule

// File: tb/tb_dom_guard_top.sv
`timescale 1ns/1ps
module tb_dom_guard_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0]  acc_master = '0, acc_periph = '0;
    logic        acc_done, acc_grant, acc_deny, acc_sema_req;

    int tests = 0;
    int fails = 0;

    bit    q_g[$];
    bit    q_s[$];
    string q_r[$];

    always #10 clk = ~clk;

    dom_guard_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_master(acc_master), .acc_periph(acc_periph),
        .acc_write(acc_write), .acc_done(acc_done), .acc_grant(acc_grant),
        .acc_deny(acc_deny), .acc_sema_req(acc_sema_req));

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && acc_done) begin
            if (q_g.size() == 0) begin
                chk(1'b0, "R7 unexpected response", {29'd0, acc_grant, acc_deny, acc_sema_req}, 32'd0);
            end else begin
                automatic bit    g = q_g.pop_front();
                automatic bit    s = q_s.pop_front();
                automatic string r = q_r.pop_front();
                chk(acc_grant == g && acc_deny == !g && acc_sema_req == s, r,
                    {29'd0, acc_grant, acc_deny, acc_sema_req}, {29'd0, g, !g, s});
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; acc_valid = 1'b0; cfg_wr = 1'b0; cfg_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg_write(input bit sel, input logic [7:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_check(input bit sel, input logic [7:0] idx, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_sel = sel; cfg_idx = idx;
        @(negedge clk);
        cfg_rd = 1'b0;
        chk(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    task automatic acc_issue(input logic [7:0] m, input logic [7:0] p, input bit w,
                             input bit g, input bit s, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_master = m; acc_periph = p; acc_write = w;
        q_g.push_back(g); q_s.push_back(s); q_r.push_back(req);
    endtask

    task automatic acc_idle();
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        do_reset();
        // R1 reset contents
        cfg_check(1'b0, 8'd0, 32'h0, "R1 master0 reset");
        cfg_check(1'b0, 8'd5, 32'h0, "R1 master5 reset");
        cfg_check(1'b1, 8'd3, 32'h0000_00FF, "R1 periph3 reset");
        acc_issue(8'd5, 8'd3, 1'b0, 1'b1, 1'b0, "R1 reset read grant");
        acc_idle();

        // R2 / R3 programming and masking
        cfg_write(1'b0, 8'd5, 32'h0000_0FF2);
        cfg_check(1'b0, 8'd5, 32'h0000_0002, "R2 master mask");
        cfg_write(1'b1, 8'd3, 32'h4000_0F23);
        cfg_check(1'b1, 8'd3, 32'h4000_0023, "R3 periph mask");

        // R5 / R6 / R8, back-to-back (R7)
        acc_issue(8'd5, 8'd3, 1'b0, 1'b1, 1'b1, "R5 d2 read grant sema R8");
        acc_issue(8'd5, 8'd3, 1'b1, 1'b0, 1'b1, "R6 d2 write deny");
        acc_issue(8'd0, 8'd3, 1'b1, 1'b1, 1'b1, "R6 d0 write grant");
        acc_issue(8'd0, 8'd3, 1'b0, 1'b1, 1'b1, "R5 d0 read grant");
        acc_idle();
        @(negedge clk);
        chk(!acc_done && !acc_deny && !acc_grant, "R7 idle quiet",
            {29'd0, acc_done, acc_grant, acc_deny}, 32'd0);

        cfg_write(1'b1, 8'd4, 32'h0000_0010);
        acc_issue(8'd5, 8'd4, 1'b1, 1'b1, 1'b0, "R6 d2 write-only grant");
        acc_issue(8'd5, 8'd4, 1'b0, 1'b0, 1'b0, "R5 d2 read deny");
        acc_idle();

        // R4 locking
        cfg_write(1'b0, 8'd6, 32'h8000_0001);
        cfg_write(1'b0, 8'd6, 32'h0000_0003);
        cfg_check(1'b0, 8'd6, 32'h8000_0001, "R4 master locked");
        acc_issue(8'd6, 8'd3, 1'b0, 1'b0, 1'b1, "R4 locked d1 read deny");
        acc_idle();
        cfg_write(1'b1, 8'd4, 32'h8000_0003);
        cfg_write(1'b1, 8'd4, 32'h0000_00FF);
        cfg_check(1'b1, 8'd4, 32'h8000_0003, "R4 periph locked");
        acc_issue(8'd5, 8'd4, 1'b0, 1'b0, 1'b0, "R4 locked policy deny");
        acc_issue(8'd0, 8'd4, 1'b0, 1'b1, 1'b0, "R4 locked policy d0 grant");
        acc_idle();

        // R9 out-of-range indices
        acc_issue(8'd200, 8'd3, 1'b0, 1'b0, 1'b1, "R9 master range deny");
        acc_issue(8'd0, 8'd200, 1'b0, 1'b0, 1'b0, "R9 periph range deny");
        acc_idle();
        cfg_write(1'b0, 8'd200, 32'h0000_0003);
        cfg_check(1'b0, 8'd200, 32'h0, "R9 master range read");
        cfg_check(1'b1, 8'd200, 32'h0, "R9 periph range read");
        cfg_check(1'b0, 8'd8, 32'h0, "R9 alias untouched");

        // R10 write and access in the same cycle
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_idx = 8'd5; cfg_wdata = 32'h0;
        acc_valid = 1'b1; acc_master = 8'd0; acc_periph = 8'd5; acc_write = 1'b0;
        q_g.push_back(1'b1); q_s.push_back(1'b0); q_r.push_back("R10 old policy used");
        @(negedge clk);
        cfg_wr = 1'b0;
        q_g.push_back(1'b0); q_s.push_back(1'b0); q_r.push_back("R10 new policy next");
        acc_idle();
        @(negedge clk);

        // R4 lock holds only until reset; R1 again
        do_reset();
        cfg_check(1'b0, 8'd6, 32'h0, "R4 master lock cleared by reset");
        cfg_check(1'b1, 8'd4, 32'h0000_00FF, "R4 periph lock cleared by reset");

        repeat (2) @(negedge clk);
        chk(q_g.size() == 0, "R7 all responses seen", q_g.size(), 32'd0);
        summary();
    end
endmodule